// File: doc/BRIEF.md
# Multi-Context Interrupt Routing Core

This block takes a set of external interrupt sources and presents them to a number of hart contexts. Every source reaches every context. Each source passes through its own gateway, which turns either a level input or a rising edge into a single pending request. The gateway then holds off any further request from that source until software reports that the current one has been handled. Software assigns each source a 3-bit priority. Each context has its own enable mask over the sources and its own 3-bit threshold. For each context, a comparison tree picks the best eligible source and drives that context's interrupt line.

Software reaches the block through a single-cycle register port with a fixed map. The high nibble of the 12-bit word address selects the region and the low byte selects the index. A read of a context's claim register returns the winning source ID and takes that source into service in the same cycle. A write of that ID to the same register completes the source and releases it.

Top module: `intr_fabric_core`

## Requirements
- R1: After reset, all priorities, enables and thresholds are 0, no source is pending, every interrupt output is low and a claim read returns 0.
- R2: A source with priority 0 never raises an interrupt output and is never returned by a claim, even while it is pending and enabled.
- R3: A pending, enabled source is eligible for a context only when its priority is strictly greater than that context's threshold.
- R4: Among eligible sources, a claim returns the one with the highest priority. When priorities are equal, the lowest source ID wins. A claim with no eligible source returns 0, and ID 0 is never a real source.
- R5: The enable masks are separate for each context, so one context can take interrupts from a source while another context ignores it.
- R6: A claim read returns the winning ID in the cycle of the read, and that source's pending bit is clear from the next cycle on.
- R7: Between a claim and the matching completion, the source stays not pending, whatever its input does.
- R8: A completion written to a context in which the named source is not enabled has no effect, and the source stays in service.
- R9: For a level-triggered source, a completion sets pending again at once if the input is still high, and leaves it clear if the input is low.
- R10: For an edge-triggered source, any number of rising edges during service are stored as one request, which becomes pending at completion. With default parameters, sources 5 to 8 are edge-triggered and sources 1 to 4 are level-triggered.
- R11: An interrupt output changes one clock cycle after the register or gateway state that decides it changes.
- R12: Register map, as 12-bit word addresses. 0x000+s holds the priority of source s in bits [2:0]. 0x100 is the read-only pending vector, with source s on bit s. 0x200+c is the enable mask of context c, with source s on bit s. 0x300+c holds the threshold of context c in bits [2:0]. 0x400+c is the claim register of context c on read and its completion register on write, taking the ID in the write data. Source s is driven on input bit s-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | External interrupt inputs, source s on bit s-1 |
| bus_re | input | 1 | Register read strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re |
| irq_o | output | NCTX | Interrupt line for each context |

## Verification
A gateway stuck in service, or one that lost its in-service flag, shows up in the pending vector on the next read. After a completion it either fails to set pending or sets pending again when it should not. A wrong enable, threshold or tie-break inside the arbiter shows up as a wrong claim ID in the very cycle of the read, and on the interrupt line one cycle later. That is why every scenario reads back claims and pending bits right after each completion, instead of waiting for effects to pile up.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    localparam int PRIO_W = 3;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [3:0] {
        RG_PRIO   = 4'h0,
        RG_PEND   = 4'h1,
        RG_ENABLE = 4'h2,
        RG_THRESH = 4'h3,
        RG_CLAIM  = 4'h4
    } region_e;

    typedef struct packed {
        logic pend;
        logic insvc;
        logic latched;
        logic prev;
    } gw_state_t;

    function automatic region_e addr_region(input logic [ADDR_W-1:0] a);
        return region_e'(a[ADDR_W-1:8]);
    endfunction

    function automatic int addr_index(input logic [ADDR_W-1:0] a);
        return int'(a[7:0]);
    endfunction
endpackage

// File: rtl/ifc_gateway.sv
module ifc_gateway
    import ifc_pkg::*;
#(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o,
    output logic insvc_o
);
    gw_state_t st;
    logic      rise;

    assign rise = src_i & ~st.prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.prev <= src_i;
            if (claim_i && st.pend) begin
                st.pend  <= 1'b0;
                st.insvc <= 1'b1;
                if (EDGE && rise) st.latched <= 1'b1;
            end else if (complete_i && st.insvc) begin
                st.insvc   <= 1'b0;
                st.latched <= 1'b0;
                st.pend    <= EDGE ? (st.latched | rise) : src_i;
            end else if (!st.insvc && !st.pend) begin
                st.pend <= EDGE ? rise : src_i;
            end else if (EDGE && st.insvc && rise) begin
                st.latched <= 1'b1;
            end
        end
    end

    assign pend_o  = st.pend;
    assign insvc_o = st.insvc;
endmodule

// File: rtl/ifc_arbiter.sv
module ifc_arbiter
    import ifc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int ID_W = 4
) (
    input  logic [NSRC:1]             pend_i,
    input  logic [NSRC:1]             en_i,
    input  logic [NSRC:1][PRIO_W-1:0] prio_i,
    input  prio_t                     thr_i,
    output logic [ID_W-1:0]           best_id_o,
    output prio_t                     best_prio_o
);
    always_comb begin
        best_id_o   = '0;
        best_prio_o = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (pend_i[s] && en_i[s] && (prio_i[s] > thr_i) && (prio_i[s] > best_prio_o)) begin
                best_id_o   = ID_W'(s);
                best_prio_o = prio_i[s];
            end
        end
    end
endmodule

// File: rtl/intr_fabric_core.sv
module intr_fabric_core
    import ifc_pkg::*;
#(
    parameter int              NSRC      = 8,
    parameter int              NCTX      = 2,
    parameter logic [NSRC-1:0] EDGE_MASK = NSRC'(8'hF0)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_re,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCTX-1:0]   irq_o
);
    localparam int ID_W  = $clog2(NSRC + 1);
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

    logic [NSRC:1][PRIO_W-1:0]           prio_q;
    logic [NCTX-1:0][NSRC:1]             en_q;
    logic [NCTX-1:0][PRIO_W-1:0]         thr_q;
    logic [NCTX-1:0]                     irq_q;
    logic [NSRC:1]                       pend_vec, insvc_vec, claim_vec, cmpl_vec;
    logic [NCTX-1:0][ID_W-1:0]           best_id;
    logic [NCTX-1:0][PRIO_W-1:0]         best_prio;

    region_e          region;
    int               idx;
    logic             ctx_ok;
    logic [CTX_W-1:0] ctx;

    assign region = addr_region(bus_addr);
    assign idx    = addr_index(bus_addr);
    assign ctx_ok = (idx < NCTX);
    assign ctx    = CTX_W'(bus_addr[7:0]);

    // per-source gateways
    for (genvar s = 1; s <= NSRC; s++) begin : g_gw
        ifc_gateway #(.EDGE(EDGE_MASK[s-1])) gw_i (
            .clk        (clk),
            .rst        (rst),
            .src_i      (src_i[s-1]),
            .claim_i    (claim_vec[s]),
            .complete_i (cmpl_vec[s]),
            .pend_o     (pend_vec[s]),
            .insvc_o    (insvc_vec[s])
        );
    end

    // per-context arbiters and output flops
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        ifc_arbiter #(.NSRC(NSRC), .ID_W(ID_W)) arb_i (
            .pend_i      (pend_vec),
            .en_i        (en_q[c]),
            .prio_i      (prio_q),
            .thr_i       (thr_q[c]),
            .best_id_o   (best_id[c]),
            .best_prio_o (best_prio[c])
        );
        always_ff @(posedge clk) begin
            if (rst) irq_q[c] <= 1'b0;
            else     irq_q[c] <= (best_id[c] != '0);
        end
    end
    assign irq_o = irq_q;

    // claim and completion strobes
    always_comb begin
        claim_vec = '0;
        cmpl_vec  = '0;
        if (region == RG_CLAIM && ctx_ok) begin
            for (int s = 1; s <= NSRC; s++) begin
                if (bus_re && best_id[ctx] == ID_W'(s))
                    claim_vec[s] = 1'b1;
                if (bus_we && bus_wdata == DATA_W'(s) && en_q[ctx][s])
                    cmpl_vec[s] = 1'b1;
            end
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (bus_we) begin
            unique case (region)
                RG_PRIO: begin
                    for (int s = 1; s <= NSRC; s++)
                        if (idx == s) prio_q[s] <= bus_wdata[PRIO_W-1:0];
                end
                RG_ENABLE: if (ctx_ok) en_q[ctx]  <= bus_wdata[NSRC:1];
                RG_THRESH: if (ctx_ok) thr_q[ctx] <= bus_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (region)
                RG_PRIO: begin
                    for (int s = 1; s <= NSRC; s++)
                        if (idx == s) bus_rdata[PRIO_W-1:0] = prio_q[s];
                end
                RG_PEND:   bus_rdata[NSRC:0] = {pend_vec, 1'b0};
                RG_ENABLE: if (ctx_ok) bus_rdata[NSRC:0] = {en_q[ctx], 1'b0};
                RG_THRESH: if (ctx_ok) bus_rdata[PRIO_W-1:0] = thr_q[ctx];
                RG_CLAIM:  if (ctx_ok) bus_rdata[ID_W-1:0] = best_id[ctx];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker
    import ifc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NCTX = 2,
    parameter int ID_W = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_re,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NCTX-1:0]             irq_o,
    input logic [NSRC:1]               pend,
    input logic [NSRC:1]               insvc,
    input logic [NCTX-1:0][NSRC:1]     en,
    input logic [NCTX-1:0][PRIO_W-1:0] thr,
    input logic [NCTX-1:0][ID_W-1:0]   best_id,
    input logic [NCTX-1:0][PRIO_W-1:0] best_prio
);
    a_r7_pend_excludes_service: assert property (@(posedge clk) disable iff (rst)
        (pend & insvc) == '0);

    a_r6_claim_clears_pending: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr[11:8] == 4'h4 && bus_rdata != '0)
        |=> !pend[$past(bus_rdata[ID_W-1:0])]);

    for (genvar c = 0; c < NCTX; c++) begin : g_c
        a_r3_above_threshold: assert property (@(posedge clk) disable iff (rst)
            (best_id[c] != '0) |-> (best_prio[c] > thr[c]));

        a_r5_disabled_ctx_quiet: assert property (@(posedge clk) disable iff (rst)
            (en[c] == '0) |=> !irq_o[c]);

        a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
            (best_id[c] != '0) |=> irq_o[c]);
    end
endmodule

bind intr_fabric_core ifc_checker #(.NSRC(NSRC), .NCTX(NCTX), .ID_W(ID_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .pend      (pend_vec),
    .insvc     (insvc_vec),
    .en        (en_q),
    .thr       (thr_q),
    .best_id   (best_id),
    .best_prio (best_prio)
);

// File: tb/intr_fabric_core_tb_top.sv
module intr_fabric_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  src_i = '0;
    logic        bus_re = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intr_fabric_core dut_i (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_re(bus_re), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [11:0] a_prio(int s); return 12'h000 + 12'(s); endfunction
    function automatic logic [11:0] a_en(int c);   return 12'h200 + 12'(c); endfunction
    function automatic logic [11:0] a_thr(int c);  return 12'h300 + 12'(c); endfunction
    function automatic logic [11:0] a_clm(int c);  return 12'h400 + 12'(c); endfunction
    localparam logic [11:0] A_PEND = 12'h100;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(logic [11:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic do_reset();
        src_i = '0; bus_re = 1'b0; bus_we = 1'b0;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 irq after reset", int'(irq_o), 0);
        reg_rd(A_PEND, d);      check("R1 pending after reset", int'(d), 0);
        reg_rd(a_prio(3), d);   check("R1 priority after reset", int'(d), 0);
        reg_rd(a_en(1), d);     check("R12 enable readback", int'(d), 0);
        reg_rd(a_clm(0), d);    check("R1 empty claim", int'(d), 0);
    endtask

    task automatic t_level_thresh();
        logic [31:0] d;
        do_reset();
        reg_wr(a_en(0), 32'h2);           // source 1 in context 0
        src_i[0] = 1'b1;
        tick(3);
        reg_rd(A_PEND, d);     check("R2 source pends with prio 0", int'(d), 2);
        check("R2 prio 0 gives no irq", int'(irq_o[0]), 0);
        reg_rd(a_clm(0), d);   check("R2 prio 0 not claimed", int'(d), 0);
        reg_wr(a_prio(1), 3);
        reg_wr(a_thr(0), 3);
        tick(2);
        check("R3 prio equal to threshold", int'(irq_o[0]), 0);
        reg_wr(a_thr(0), 2);
        check("R11 irq not yet raised", int'(irq_o[0]), 0);
        tick(1);
        check("R11 irq one cycle later", int'(irq_o[0]), 1);
        reg_rd(a_clm(0), d);   check("R6 claim returns id", int'(d), 1);
        reg_rd(A_PEND, d);     check("R6 pending cleared", int'(d), 0);
        tick(3);
        reg_rd(A_PEND, d);     check("R7 no re-pend in service", int'(d), 0);
        check("R7 irq low in service", int'(irq_o[0]), 0);
        reg_wr(a_clm(0), 1);
        reg_rd(A_PEND, d);     check("R9 level re-pends when high", int'(d), 2);
        src_i[0] = 1'b0;
        reg_rd(a_clm(0), d);   check("R9 second claim", int'(d), 1);
        reg_wr(a_clm(0), 1);
        reg_rd(A_PEND, d);     check("R9 no re-pend when low", int'(d), 0);
        tick(1);
        check("R9 irq drops", int'(irq_o[0]), 0);
    endtask

    task automatic t_arbitration();
        logic [31:0] d;
        do_reset();
        reg_wr(a_prio(2), 5);
        reg_wr(a_prio(3), 5);
        reg_wr(a_prio(4), 2);
        reg_wr(a_en(0), 32'h1C);
        src_i[3:1] = 3'b111;
        tick(2);
        reg_rd(a_clm(0), d);   check("R4 tie goes to lower id", int'(d), 2);
        reg_rd(a_clm(0), d);   check("R4 next equal priority", int'(d), 3);
        reg_rd(a_clm(0), d);   check("R4 lowest priority last", int'(d), 4);
        reg_rd(a_clm(0), d);   check("R4 none left returns 0", int'(d), 0);
        reg_wr(a_prio(4), 7);
        reg_wr(a_clm(0), 2);
        reg_wr(a_clm(0), 4);
        reg_rd(a_clm(0), d);   check("R4 higher priority wins", int'(d), 4);
    endtask

    task automatic t_contexts();
        logic [31:0] d;
        do_reset();
        reg_wr(a_prio(2), 4);
        reg_wr(a_en(1), 32'h4);
        src_i[1] = 1'b1;
        tick(3);
        check("R5 enabled context irq", int'(irq_o[1]), 1);
        check("R5 other context quiet", int'(irq_o[0]), 0);
        reg_rd(a_clm(0), d);   check("R5 other context claims 0", int'(d), 0);
        reg_rd(a_clm(1), d);   check("R5 enabled context claims", int'(d), 2);
        reg_wr(a_clm(0), 2);
        tick(1);
        reg_rd(A_PEND, d);     check("R8 foreign completion ignored", int'(d), 0);
        reg_wr(a_clm(1), 2);
        reg_rd(A_PEND, d);     check("R8 own completion releases", int'(d), 4);
    endtask

    task automatic pulse(int bitpos);
        src_i[bitpos] = 1'b1; tick(1);
        src_i[bitpos] = 1'b0; tick(1);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        reg_wr(a_prio(5), 1);
        reg_wr(a_en(0), 32'h20);
        pulse(4);
        reg_rd(A_PEND, d);     check("R10 edge pends", int'(d), 32);
        reg_rd(a_clm(0), d);   check("R10 edge claim", int'(d), 5);
        pulse(4);
        pulse(4);
        reg_rd(A_PEND, d);     check("R10 held during service", int'(d), 0);
        reg_wr(a_clm(0), 5);
        reg_rd(A_PEND, d);     check("R10 latched edge pends", int'(d), 32);
        reg_rd(a_clm(0), d);   check("R10 second claim", int'(d), 5);
        reg_wr(a_clm(0), 5);
        reg_rd(A_PEND, d);     check("R10 only one edge stored", int'(d), 0);
        src_i[4] = 1'b1;
        tick(3);
        reg_rd(a_clm(0), d);   check("R10 held-high edge claim", int'(d), 5);
        reg_wr(a_clm(0), 5);
        tick(2);
        reg_rd(A_PEND, d);     check("R10 steady high no re-pend", int'(d), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_level_thresh();
        t_arbitration();
        t_contexts();
        t_edge();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule